// File: doc/BRIEF.md
# Pad Ownership and Lock Gate

This block decides, for every pad of a pad bank, whether host software is still allowed to change that pad's configuration. It holds three kinds of control words: ownership words with one 4-bit owner field per pad, host-mode words with one bit per pad, and a pair of lock words for each pad group. All of these words are loaded through a simple register bus. From these words the block drives a per-pad `pad_usable` vector and a per-pad `pad_fw_mode` vector.

Configuration writes headed for the pad configuration storage pass through the block. A write strobe goes out only when the addressed pad is usable. Any write that is refused, including one to a pad index outside the bank, sets a sticky error flag. Software reads that flag and clears it through the same register bus.

Pads are split into groups of `GROUP_SIZE`. Each of the three register families has its own base offset, set by a parameter. A base of zero removes that family: it gets no storage, it reads as zero, and it takes the permissive default. The pins are plain control pins. There is no back-pressure: a refused write is lost, and the error flag reports it.

Top module: `pad_gate`

## Requirements
- R1: For pad p, let g = p / GROUP_SIZE and i = p % GROUP_SIZE. The owner field of pad p is bits [4*(i%8)+3 : 4*(i%8)] of the 32-bit word at byte address OWN_BASE + 0x10*g + 4*(i/8). The pad is host-owned only when that field is 0; any nonzero value makes it not usable.
- R2: Bit i of the host-mode word at HOST_BASE + 4*g belongs to pad p. When that bit is 0, `pad_fw_mode[p]` is 1. This bit has no effect on `pad_usable`.
- R3: Bit i of the configuration-lock word at LOCK_BASE + 8*g, or bit i of the transmit-lock word at LOCK_BASE + 8*g + 4, makes pad p locked when set. A locked pad is not usable.
- R4: `pad_usable[p]` is 1 exactly when pad p is host-owned and not locked. It reflects a register write from the clock cycle after the write.
- R5: A base parameter of 0 removes its register family. An absent ownership family counts every pad as owned, an absent lock family counts every pad as unlocked, and an absent host-mode family gives `pad_fw_mode` = 0. Writes to the unused addresses change nothing, and those addresses read 0.
- R6: `cfg_we_out` is `cfg_we_in` AND the usability of the pad on `cfg_pad`, with no added delay.
- R7: A `cfg_we_in` that is refused sets `cfg_err` at the next clock edge. The flag stays set until a register write to ERR_ADDR with wdata bit 0 = 1. When a clear and a new refusal happen in the same cycle, the flag stays set. ERR_ADDR reads {31'b0, cfg_err}.
- R8: A `cfg_pad` value of NUM_PADS or more is never usable. A write to such an index is refused and sets `cfg_err`.
- R9: After reset, all owner fields and lock words are 0, all host-mode bits are 1, and `cfg_err` is 0. So every pad is usable and no pad is in firmware mode.
- R10: `csr_rdata` is combinational from `csr_addr`. It returns the stored word, with host-mode and lock words zero-extended from GROUP_SIZE bits. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | ADDR_W | Register byte address (write and read) |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for csr_addr |
| cfg_we_in | input | 1 | Incoming pad configuration write strobe |
| cfg_pad | input | PAD_W | Pad index of the incoming configuration write |
| cfg_we_out | output | 1 | Gated write strobe to pad configuration storage |
| cfg_err | output | 1 | Sticky refused-write flag |
| pad_usable | output | NUM_PADS | Per-pad usable flag |
| pad_fw_mode | output | NUM_PADS | Per-pad firmware-mode flag |

## Verification
If a stored word is wrong, or a pad index is decoded to the wrong word, bit or nibble, the fault shows on `pad_usable` or `pad_fw_mode` at the first sampling point after the write. The bench therefore probes a pad in each group, at the low and high nibble and bit positions, and includes the partial last group. The same fault reaches `cfg_we_out` in that same cycle. It also reaches `cfg_err` one edge later, so the bench compares the gate and the flag against the usable vector. A lost or stuck error flag shows through the readback of ERR_ADDR and through the clear/set collision case.

// File: rtl/pad_gate_pkg.sv
package pad_gate_pkg;
  localparam int CSR_DW          = 32;
  localparam int OWN_FIELD_W     = 4;
  localparam int PADS_PER_OWN_WD = CSR_DW / OWN_FIELD_W;
  localparam int OWN_GRP_STRIDE  = 16;
  localparam int OWN_WD_STRIDE   = 4;
  localparam int HOST_STRIDE     = 4;
  localparam int LOCK_GRP_STRIDE = 8;
  localparam int TXLOCK_OFS      = 4;

  function automatic int own_addr(int base, int grp, int wd);
    return base + OWN_GRP_STRIDE * grp + OWN_WD_STRIDE * wd;
  endfunction

  function automatic int host_addr(int base, int grp);
    return base + HOST_STRIDE * grp;
  endfunction

  function automatic int lock_addr(int base, int grp, bit tx);
    return base + LOCK_GRP_STRIDE * grp + (tx ? TXLOCK_OFS : 0);
  endfunction
endpackage

// File: rtl/pad_gate_regs.sv
module pad_gate_regs
  import pad_gate_pkg::*;
#(
  parameter int NUM_GROUPS = 3,
  parameter int GROUP_SIZE = 16,
  parameter int OWN_WPG    = 2,
  parameter int ADDR_W     = 12,
  parameter int OWN_BASE   = 'h100,
  parameter int HOST_BASE  = 'h200,
  parameter int LOCK_BASE  = 'h300
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     csr_we,
  input  logic [ADDR_W-1:0]                        csr_addr,
  input  logic [CSR_DW-1:0]                        csr_wdata,
  output logic [NUM_GROUPS*OWN_WPG-1:0][CSR_DW-1:0] own_q,
  output logic [NUM_GROUPS-1:0][GROUP_SIZE-1:0]    host_q,
  output logic [NUM_GROUPS-1:0][GROUP_SIZE-1:0]    cfglk_q,
  output logic [NUM_GROUPS-1:0][GROUP_SIZE-1:0]    txlk_q,
  output logic [CSR_DW-1:0]                        rd_data
);

  logic [CSR_DW-1:0] rd_own, rd_host, rd_lock;

  // Ownership family: OWN_WPG words per group
  if (OWN_BASE != 0) begin : g_own
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        own_q <= '0;
      end else if (csr_we) begin
        for (int g = 0; g < NUM_GROUPS; g++)
          for (int w = 0; w < OWN_WPG; w++)
            if (csr_addr == ADDR_W'(own_addr(OWN_BASE, g, w)))
              own_q[g*OWN_WPG+w] <= csr_wdata;
      end
    end
    always_comb begin
      rd_own = '0;
      for (int g = 0; g < NUM_GROUPS; g++)
        for (int w = 0; w < OWN_WPG; w++)
          if (csr_addr == ADDR_W'(own_addr(OWN_BASE, g, w)))
            rd_own = own_q[g*OWN_WPG+w];
    end
  end else begin : g_no_own
    assign own_q  = '0;
    assign rd_own = '0;
  end

  // Host-mode family: one word per group
  if (HOST_BASE != 0) begin : g_host
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        host_q <= '1;
      end else if (csr_we) begin
        for (int g = 0; g < NUM_GROUPS; g++)
          if (csr_addr == ADDR_W'(host_addr(HOST_BASE, g)))
            host_q[g] <= csr_wdata[GROUP_SIZE-1:0];
      end
    end
    always_comb begin
      rd_host = '0;
      for (int g = 0; g < NUM_GROUPS; g++)
        if (csr_addr == ADDR_W'(host_addr(HOST_BASE, g)))
          rd_host = CSR_DW'(host_q[g]);
    end
  end else begin : g_no_host
    assign host_q  = '1;
    assign rd_host = '0;
  end

  // Lock family: configuration lock and transmit lock per group
  if (LOCK_BASE != 0) begin : g_lock
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfglk_q <= '0;
        txlk_q  <= '0;
      end else if (csr_we) begin
        for (int g = 0; g < NUM_GROUPS; g++) begin
          if (csr_addr == ADDR_W'(lock_addr(LOCK_BASE, g, 1'b0)))
            cfglk_q[g] <= csr_wdata[GROUP_SIZE-1:0];
          if (csr_addr == ADDR_W'(lock_addr(LOCK_BASE, g, 1'b1)))
            txlk_q[g] <= csr_wdata[GROUP_SIZE-1:0];
        end
      end
    end
    always_comb begin
      rd_lock = '0;
      for (int g = 0; g < NUM_GROUPS; g++) begin
        if (csr_addr == ADDR_W'(lock_addr(LOCK_BASE, g, 1'b0)))
          rd_lock = CSR_DW'(cfglk_q[g]);
        if (csr_addr == ADDR_W'(lock_addr(LOCK_BASE, g, 1'b1)))
          rd_lock = CSR_DW'(txlk_q[g]);
      end
    end
  end else begin : g_no_lock
    assign cfglk_q = '0;
    assign txlk_q  = '0;
    assign rd_lock = '0;
  end

  // Families occupy disjoint address windows, so OR-ing is a mux
  assign rd_data = rd_own | rd_host | rd_lock;

endmodule

// File: rtl/pad_gate_eval.sv
module pad_gate_eval
  import pad_gate_pkg::*;
#(
  parameter int NUM_PADS   = 40,
  parameter int NUM_GROUPS = 3,
  parameter int GROUP_SIZE = 16,
  parameter int OWN_WPG    = 2
) (
  input  logic [NUM_GROUPS*OWN_WPG-1:0][CSR_DW-1:0] own_q,
  input  logic [NUM_GROUPS-1:0][GROUP_SIZE-1:0]    host_q,
  input  logic [NUM_GROUPS-1:0][GROUP_SIZE-1:0]    cfglk_q,
  input  logic [NUM_GROUPS-1:0][GROUP_SIZE-1:0]    txlk_q,
  output logic [NUM_PADS-1:0]                      usable,
  output logic [NUM_PADS-1:0]                      fw_mode
);

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    localparam int GRP = p / GROUP_SIZE;
    localparam int IDX = p % GROUP_SIZE;
    localparam int WRD = GRP * OWN_WPG + IDX / PADS_PER_OWN_WD;
    localparam int NIB = IDX % PADS_PER_OWN_WD;

    logic owned, locked;
    assign owned      = (own_q[WRD][NIB*OWN_FIELD_W +: OWN_FIELD_W] == '0);
    assign locked     = cfglk_q[GRP][IDX] | txlk_q[GRP][IDX];
    assign usable[p]  = owned & ~locked;
    assign fw_mode[p] = ~host_q[GRP][IDX];
  end

  // Slots past the last pad of a partial group feed no pad
  logic unused_slots;
  assign unused_slots = ^{own_q, host_q, cfglk_q, txlk_q};

endmodule

// File: rtl/pad_gate_wgate.sv
module pad_gate_wgate #(
  parameter int NUM_PADS = 40,
  parameter int PAD_W    = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] usable,
  input  logic                cfg_we_in,
  input  logic [PAD_W-1:0]    cfg_pad,
  input  logic                err_clr,
  output logic                cfg_we_out,
  output logic                err
);

  logic pad_ok;

  // Out-of-range indices match no pad and so stay not usable
  always_comb begin
    pad_ok = 1'b0;
    for (int p = 0; p < NUM_PADS; p++)
      if (cfg_pad == PAD_W'(p)) pad_ok = usable[p];
  end

  assign cfg_we_out = cfg_we_in & pad_ok;

  always_ff @(posedge clk) begin
    if (!rst_n)                  err <= 1'b0;
    else if (cfg_we_in && !pad_ok) err <= 1'b1;
    else if (err_clr)            err <= 1'b0;
  end

endmodule

// File: rtl/pad_gate.sv
module pad_gate
  import pad_gate_pkg::*;
#(
  parameter int NUM_PADS   = 40,
  parameter int GROUP_SIZE = 16,
  parameter int ADDR_W     = 12,
  parameter int OWN_BASE   = 'h100,
  parameter int HOST_BASE  = 'h200,
  parameter int LOCK_BASE  = 'h300,
  parameter int ERR_ADDR   = 'h004,
  localparam int PAD_W     = $clog2(NUM_PADS) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                csr_we,
  input  logic [ADDR_W-1:0]   csr_addr,
  input  logic [31:0]         csr_wdata,
  output logic [31:0]         csr_rdata,
  input  logic                cfg_we_in,
  input  logic [PAD_W-1:0]    cfg_pad,
  output logic                cfg_we_out,
  output logic                cfg_err,
  output logic [NUM_PADS-1:0] pad_usable,
  output logic [NUM_PADS-1:0] pad_fw_mode
);

  localparam int NUM_GROUPS = (NUM_PADS + GROUP_SIZE - 1) / GROUP_SIZE;
  localparam int OWN_WPG    = (GROUP_SIZE + PADS_PER_OWN_WD - 1) / PADS_PER_OWN_WD;

  logic [NUM_GROUPS*OWN_WPG-1:0][CSR_DW-1:0] own_q;
  logic [NUM_GROUPS-1:0][GROUP_SIZE-1:0]    host_q, cfglk_q, txlk_q;
  logic [CSR_DW-1:0]                        reg_rd;
  logic                                     err_sel, err_clr;

  pad_gate_regs #(
    .NUM_GROUPS(NUM_GROUPS), .GROUP_SIZE(GROUP_SIZE), .OWN_WPG(OWN_WPG),
    .ADDR_W(ADDR_W), .OWN_BASE(OWN_BASE), .HOST_BASE(HOST_BASE),
    .LOCK_BASE(LOCK_BASE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .own_q(own_q), .host_q(host_q),
    .cfglk_q(cfglk_q), .txlk_q(txlk_q), .rd_data(reg_rd)
  );

  pad_gate_eval #(
    .NUM_PADS(NUM_PADS), .NUM_GROUPS(NUM_GROUPS), .GROUP_SIZE(GROUP_SIZE),
    .OWN_WPG(OWN_WPG)
  ) u_eval (
    .own_q(own_q), .host_q(host_q), .cfglk_q(cfglk_q), .txlk_q(txlk_q),
    .usable(pad_usable), .fw_mode(pad_fw_mode)
  );

  assign err_sel = (csr_addr == ADDR_W'(ERR_ADDR));
  assign err_clr = csr_we & err_sel & csr_wdata[0];

  pad_gate_wgate #(.NUM_PADS(NUM_PADS), .PAD_W(PAD_W)) u_wgate (
    .clk(clk), .rst_n(rst_n), .usable(pad_usable), .cfg_we_in(cfg_we_in),
    .cfg_pad(cfg_pad), .err_clr(err_clr), .cfg_we_out(cfg_we_out),
    .err(cfg_err)
  );

  assign csr_rdata = err_sel ? {31'b0, cfg_err} : reg_rd;

endmodule

// File: rtl/pad_gate_chk.sv
module pad_gate_chk #(
  parameter int NUM_PADS = 40,
  parameter int ADDR_W   = 12,
  parameter int ERR_ADDR = 'h004,
  parameter int PAD_W    = 7
) (
  input logic                clk,
  input logic                rst_n,
  input logic                csr_we,
  input logic [ADDR_W-1:0]   csr_addr,
  input logic [31:0]         csr_wdata,
  input logic                cfg_we_in,
  input logic [PAD_W-1:0]    cfg_pad,
  input logic                cfg_we_out,
  input logic                cfg_err,
  input logic [NUM_PADS-1:0] pad_usable
);

  // R6: the gate never creates a write
  a_r6_no_spurious_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we_out |-> cfg_we_in);

  // R8: out-of-range index never passes
  a_r8_range_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_in && cfg_pad >= PAD_W'(NUM_PADS)) |-> !cfg_we_out);

  // R7: a refused write raises the flag
  a_r7_refusal_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_in && !cfg_we_out) |=> cfg_err);

  // R7: the flag holds until an explicit clear
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !(csr_we && csr_addr == ADDR_W'(ERR_ADDR) && csr_wdata[0]))
      |=> cfg_err);

  // R9: flag is clear when reset releases
  a_r9_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !cfg_err);

  // R4: usability changes only after a register write
  a_r4_stable_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!csr_we && !$rose(rst_n)) |=> $stable(pad_usable));

endmodule

bind pad_gate pad_gate_chk #(
  .NUM_PADS(NUM_PADS), .ADDR_W(ADDR_W), .ERR_ADDR(ERR_ADDR), .PAD_W(PAD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
  .csr_wdata(csr_wdata), .cfg_we_in(cfg_we_in), .cfg_pad(cfg_pad),
  .cfg_we_out(cfg_we_out), .cfg_err(cfg_err), .pad_usable(pad_usable)
);

// File: tb/pad_gate_test.sv
`timescale 1ns/100ps
module pad_gate_test;
  localparam int NP = 40;
  localparam int PW = 7;
  localparam logic [11:0] ERRA = 12'h004;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csr_we = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic cfg_we_in = 1'b0;
  logic [PW-1:0] cfg_pad = '0;
  logic [31:0] rdata, rdata_b;
  logic we_out, we_out_b, err, err_b;
  logic [NP-1:0] usable, fw, usable_b, fw_b;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pad_gate uut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(rdata), .cfg_we_in(cfg_we_in),
    .cfg_pad(cfg_pad), .cfg_we_out(we_out), .cfg_err(err),
    .pad_usable(usable), .pad_fw_mode(fw)
  );

  // Host-mode and lock families absent
  pad_gate #(.HOST_BASE(0), .LOCK_BASE(0)) uut_absent (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(rdata_b), .cfg_we_in(cfg_we_in),
    .cfg_pad(cfg_pad), .cfg_we_out(we_out_b), .cfg_err(err_b),
    .pad_usable(usable_b), .pad_fw_mode(fw_b)
  );

  typedef struct packed {
    logic [11:0] addr;
    logic [31:0] data;
    logic [6:0]  pad;
    logic        u;
    logic        f;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{12'h100, 32'h0000_0010, 7'd1,  1'b0, 1'b0, 4'd1},
    '{12'h100, 32'h0000_0010, 7'd0,  1'b1, 1'b0, 4'd1},
    '{12'h100, 32'h0000_0000, 7'd1,  1'b1, 1'b0, 4'd1},
    '{12'h114, 32'hF000_0000, 7'd31, 1'b0, 1'b0, 4'd1},
    '{12'h114, 32'h0000_0000, 7'd31, 1'b1, 1'b0, 4'd1},
    '{12'h120, 32'h0000_0200, 7'd34, 1'b0, 1'b0, 4'd1},
    '{12'h120, 32'h0000_0000, 7'd34, 1'b1, 1'b0, 4'd1},
    '{12'h308, 32'h0000_0020, 7'd21, 1'b0, 1'b0, 4'd3},
    '{12'h308, 32'h0000_0000, 7'd21, 1'b1, 1'b0, 4'd3},
    '{12'h304, 32'h0000_8000, 7'd15, 1'b0, 1'b0, 4'd3},
    '{12'h304, 32'h0000_0000, 7'd15, 1'b1, 1'b0, 4'd3},
    '{12'h208, 32'hFFFF_FFFE, 7'd32, 1'b1, 1'b1, 4'd2},
    '{12'h208, 32'hFFFF_FFFF, 7'd32, 1'b1, 1'b0, 4'd2},
    '{12'h200, 32'hFFFF_FF7F, 7'd7,  1'b1, 1'b1, 4'd2},
    '{12'h200, 32'hFFFF_FFFF, 7'd7,  1'b1, 1'b0, 4'd2}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic csr_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_read(input logic [11:0] a);
    csr_addr = a;
    #1;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: reset state
    chk("R9 usable", 64'(usable), {24'b0, {NP{1'b1}}});
    chk("R9 fw_mode", 64'(fw), 64'd0);
    chk("R9 err", 64'(err), 64'd0);
    // R10: readback of reset words and unmapped space
    csr_read(12'h200); chk("R10 host reset", 64'(rdata), 64'h0000_FFFF);
    csr_read(12'h304); chk("R10 lock reset", 64'(rdata), 64'd0);
    csr_read(12'h0F0); chk("R10 unmapped", 64'(rdata), 64'd0);

    // Table walk: R1 ownership, R2 host mode, R3 locks, R4/R6/R7 gating
    for (int k = 0; k < NV; k++) begin
      csr_write(VEC[k].addr, VEC[k].data);
      chk($sformatf("R%0d usable pad %0d", VEC[k].rq, VEC[k].pad),
          64'(usable[VEC[k].pad]), 64'(VEC[k].u));
      chk($sformatf("R2 fw_mode pad %0d", VEC[k].pad),
          64'(fw[VEC[k].pad]), 64'(VEC[k].f));
      cfg_we_in = 1'b1; cfg_pad = VEC[k].pad;
      #1;
      chk("R6 gate", 64'(we_out), 64'(VEC[k].u));
      @(negedge clk);
      cfg_we_in = 1'b0;
      chk("R7 err after gate", 64'(err), 64'(!VEC[k].u));
      csr_write(ERRA, 32'h1);
    end

    // R1: ownership word readback and any nonzero field blocks
    csr_write(12'h110, 32'hDEAD_BEEF);
    csr_read(12'h110); chk("R1 readback", 64'(rdata), 64'hDEAD_BEEF);
    chk("R1 group1 low word", 64'(usable[23:16]), 64'd0);
    chk("R1 group1 high word free", 64'(usable[31:24]), 64'hFF);
    csr_write(12'h110, 32'h0);

    // R3: both lock words set on one pad, then one released
    csr_write(12'h310, 32'h0000_0001);
    csr_write(12'h314, 32'h0000_0001);
    chk("R3 both locks", 64'(usable[32]), 64'd0);
    csr_write(12'h310, 32'h0);
    chk("R3 tx lock alone", 64'(usable[32]), 64'd0);
    csr_write(12'h314, 32'h0);
    chk("R3 released", 64'(usable[32]), 64'd1);

    // R8: out-of-range indices
    @(negedge clk);
    cfg_we_in = 1'b1; cfg_pad = 7'd40; #1;
    chk("R8 pad 40 gate", 64'(we_out), 64'd0);
    @(negedge clk);
    cfg_pad = 7'd127; #1;
    chk("R8 pad 127 gate", 64'(we_out), 64'd0);
    chk("R8 err set", 64'(err), 64'd1);

    // R7: clear and refusal in the same cycle, flag stays set
    csr_we = 1'b1; csr_addr = ERRA; csr_wdata = 32'h1;
    @(negedge clk);
    csr_we = 1'b0; cfg_we_in = 1'b0;
    chk("R7 set wins", 64'(err), 64'd1);
    csr_read(ERRA); chk("R7 err readback", 64'(rdata), 64'd1);
    csr_write(ERRA, 32'h0);
    chk("R7 clear needs bit0", 64'(err), 64'd1);
    csr_write(ERRA, 32'h1);
    chk("R7 cleared", 64'(err), 64'd0);

    // R5: instance without host-mode and lock families
    csr_write(12'h300, 32'hFFFF_FFFF);
    csr_write(12'h200, 32'h0);
    chk("R5 absent lock usable", 64'(usable_b), {24'b0, {NP{1'b1}}});
    chk("R5 absent host fw", 64'(fw_b), 64'd0);
    csr_read(12'h300); chk("R5 absent reads zero", 64'(rdata_b), 64'd0);
    chk("R5 present lock bites", 64'(usable[15:0]), 64'd0);
    chk("R2 host clear no usable effect", 64'(usable[31:16]), 64'hFFFF);
    csr_write(12'h100, 32'h0000_0003);
    chk("R5 ownership still present", 64'(usable_b[0]), 64'd0);

    finish_run();
  end
endmodule